// File: doc/BRIEF.md
# Serial-Programmed Clock Fan-out Enable Controller

This block takes one reference clock and produces eighteen gated copies of it. Each copy has its own enable bit. The enable bits live in a three-byte configuration bank. That bank is loaded over a two-wire serial bus that follows SMBus/I2C write timing. The block acts only as a write slave on that bus. It samples SCL and SDA on a system clock, recognises START and STOP conditions, matches its 7-bit address and acknowledges by pulling SDA low. It then loads data bytes one after another into the bank.

The bank comes out of reset with every copy enabled. A set bit lets its copy follow the reference clock. A cleared bit holds that copy low. An enable change takes effect only on a falling edge of the reference clock, so a gated copy never shows a shortened high phase. A separate active-high drive-enable pin decides, for all eighteen outputs at once, whether they are driven or left high-impedance. The last two copies are meant as feedback clocks for an external PLL.

Top module: `clkgate_smbus_ctrl`

## Requirements
- R1: After reset all 18 copies are enabled (the bank holds 0xFF, 0xFF, 0xC0) and the block leaves SDA released (`sda_oe` = 0).
- R2: An address byte of 7-bit address 1101001 followed by a write bit of 0 (byte 0xD2) is acknowledged: `sda_oe` = 1 while SCL is high during the ninth clock. Any other address gets no acknowledge and changes nothing.
- R3: A matching address with the read bit set (byte 0xD3) gets no acknowledge. The block drives no data in reply, and the bank is unchanged.
- R4: After an acknowledged address, data bytes load bank bytes 0, 1 and 2 in that order, MSB first, and each data byte is acknowledged.
- R5: Bit k of byte 0 enables copy k. Bit k of byte 1 enables copy 8+k. Bit 7 of byte 2 enables copy 17 and bit 6 of byte 2 enables copy 16. Bits 5..0 of byte 2 are stored but affect no output.
- R6: A copy whose bit is 1 equals `clk_in`. A copy whose bit is 0 is held at 0.
- R7: `clk_oe[i]` = 1 (driven) for every i when `out_en` is 1, and 0 (high-impedance) for every i when `out_en` is 0.
- R8: A data byte is written to the bank only at the end of its acknowledge clock. A STOP in the middle of a byte leaves the bank unchanged.
- R9: A STOP or a repeated START returns the byte pointer to byte 0.
- R10: Data bytes after the third are acknowledged and discarded.
- R11: A copy's enable changes only on a falling edge of `clk_in`. No copy changes value while `clk_in` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock that oversamples the serial bus |
| sys_rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial bus clock line |
| sda_in | input | 1 | Serial bus data line (resolved open-drain level) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| clk_in | input | 1 | Reference clock to be fanned out |
| out_en | input | 1 | Active-high drive enable for all outputs |
| clk_out | output | 18 | Gated copies of `clk_in` |
| clk_oe | output | 18 | Per-output driver enable, 1 = driven, 0 = high-impedance |

## Verification
Directed transactions separate the decoding cases that can be confused with one another: a wrong address, a read request, a single byte, a repeated START in mid-stream, a run of five bytes and a STOP cut into a byte. Each case shows a different way the pointer, the acknowledge or the commit could go wrong. Walking patterns through byte 2, with the reserved bits set, tell the two feedback copies apart from the ignored bits. Random byte counts and values then exercise the full bit-to-output map against a model kept in the bench. Each output check samples twice inside one high phase of the reference clock, which exposes any enable change that is not aligned to a falling edge.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  localparam int NUM_OUT       = 18;
  localparam int CFG_BYTES     = 3;
  localparam int CFG_BITS      = CFG_BYTES * 8;
  localparam int PTR_W         = $clog2(CFG_BYTES + 1);
  localparam logic [CFG_BITS-1:0] CFG_RESET = {8'hC0, 8'hFF, 8'hFF};

  typedef enum logic [2:0] {
    SL_IDLE, SL_ADDR, SL_AACK, SL_DATA, SL_DACK
  } slave_st_e;

  // Address byte selects this slave for a write.
  function automatic logic addr_write_hit(input logic [7:0] b, input logic [6:0] addr);
    return (b[7:1] == addr) && !b[0];
  endfunction

  // Map configuration bank to per-output enables; reserved bits dropped.
  function automatic logic [NUM_OUT-1:0] cfg_to_enable(input logic [CFG_BITS-1:0] cfg);
    logic [NUM_OUT-1:0] en;
    en[15:0]  = cfg[15:0];
    en[16]    = cfg[22];
    en[17]    = cfg[23];
    return en;
  endfunction
endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [1:0] scl_pipe, sda_pipe;
  logic       scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= 2'b11;
      sda_pipe <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[0], scl_raw};
      sda_pipe <= {sda_pipe[0], sda_raw};
      scl_d    <= scl_pipe[1];
      sda_d    <= sda_pipe[1];
    end
  end

  assign scl_s     = scl_pipe[1];
  assign sda_s     = sda_pipe[1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smbus_wr_slave.sv
module smbus_wr_slave
  import clkgate_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'b1101001
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sda_s,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_evt,
  input  logic                stop_evt,
  output logic                sda_oe,
  output logic [CFG_BITS-1:0] cfg
);
  slave_st_e        state;
  logic [3:0]       bit_cnt;
  logic [7:0]       shreg;
  logic [PTR_W-1:0] byte_ptr;
  logic             byte_full;

  assign byte_full = (bit_cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SL_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_ptr <= '0;
      sda_oe   <= 1'b0;
      cfg      <= CFG_RESET;
    end else if (start_evt) begin
      state    <= SL_ADDR;
      bit_cnt  <= '0;
      byte_ptr <= '0;
      sda_oe   <= 1'b0;
    end else if (stop_evt) begin
      state    <= SL_IDLE;
      byte_ptr <= '0;
      sda_oe   <= 1'b0;
    end else begin
      unique case (state)
        SL_ADDR, SL_DATA: begin
          if (scl_rise && !byte_full) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && byte_full) begin
            if (state == SL_DATA) begin
              sda_oe <= 1'b1;
              state  <= SL_DACK;
            end else if (addr_write_hit(shreg, SLAVE_ADDR)) begin
              sda_oe <= 1'b1;
              state  <= SL_AACK;
            end else begin
              state  <= SL_IDLE;
            end
          end
        end
        SL_AACK: if (scl_fall) begin
          sda_oe  <= 1'b0;
          bit_cnt <= '0;
          state   <= SL_DATA;
        end
        SL_DACK: if (scl_fall) begin
          sda_oe  <= 1'b0;
          bit_cnt <= '0;
          state   <= SL_DATA;
          if (byte_ptr < PTR_W'(CFG_BYTES)) begin
            for (int k = 0; k < CFG_BYTES; k++)
              if (byte_ptr == PTR_W'(k)) cfg[k*8 +: 8] <= shreg;
            byte_ptr <= byte_ptr + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
  parameter int N = 18
) (
  input  logic         clk_in,
  input  logic         rst_n,
  input  logic         out_en,
  input  logic [N-1:0] en_req,
  output logic [N-1:0] gate_en,
  output logic [N-1:0] clk_out,
  output logic [N-1:0] clk_oe
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    always_ff @(negedge clk_in or negedge rst_n) begin
      if (!rst_n) gate_en[i] <= 1'b1;
      else        gate_en[i] <= en_req[i];
    end
    assign clk_out[i] = clk_in & gate_en[i];
    assign clk_oe[i]  = out_en;
  end
endmodule

// File: rtl/clkgate_smbus_ctrl.sv
module clkgate_smbus_ctrl
  import clkgate_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'b1101001
) (
  input  logic               sys_clk,
  input  logic               sys_rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  input  logic               clk_in,
  input  logic               out_en,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] clk_oe
);
  logic                scl_sync, sda_sync;
  logic                scl_rise_evt, scl_fall_evt, start_evt, stop_evt;
  logic [CFG_BITS-1:0] cfg_flat;
  logic [NUM_OUT-1:0]  en_req, gate_en;

  smbus_line_sync u_sync (
    .clk       (sys_clk),
    .rst_n     (sys_rst_n),
    .scl_raw   (scl_in),
    .sda_raw   (sda_in),
    .scl_s     (scl_sync),
    .sda_s     (sda_sync),
    .scl_rise  (scl_rise_evt),
    .scl_fall  (scl_fall_evt),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  smbus_wr_slave #(.SLAVE_ADDR(SLAVE_ADDR)) u_slave (
    .clk       (sys_clk),
    .rst_n     (sys_rst_n),
    .sda_s     (sda_sync),
    .scl_rise  (scl_rise_evt),
    .scl_fall  (scl_fall_evt),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_oe    (sda_oe),
    .cfg       (cfg_flat)
  );

  assign en_req = cfg_to_enable(cfg_flat);

  clk_gate_bank #(.N(NUM_OUT)) u_gates (
    .clk_in  (clk_in),
    .rst_n   (sys_rst_n),
    .out_en  (out_en),
    .en_req  (en_req),
    .gate_en (gate_en),
    .clk_out (clk_out),
    .clk_oe  (clk_oe)
  );
endmodule

// File: rtl/clkgate_smbus_chk.sv
module clkgate_smbus_chk
  import clkgate_pkg::*;
(
  input logic                sys_clk,
  input logic                sys_rst_n,
  input logic                scl_sync,
  input logic                sda_oe,
  input logic                stop_evt,
  input logic                clk_in,
  input logic [NUM_OUT-1:0]  gate_en,
  input logic [CFG_BITS-1:0] cfg_flat
);
  AST_ACK_ON_SCL_LOW: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $rose(sda_oe) |-> !scl_sync); // R2

  AST_COMMIT_IN_ACK: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !$stable(cfg_flat) |-> $past(sda_oe)); // R8

  AST_STOP_RELEASES_SDA: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    stop_evt |=> !sda_oe); // R9

  AST_GATE_HOLD_HIGH: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (clk_in && $past(clk_in)) |-> $stable(gate_en)); // R11
endmodule

bind clkgate_smbus_ctrl clkgate_smbus_chk u_chk (
  .sys_clk   (sys_clk),
  .sys_rst_n (sys_rst_n),
  .scl_sync  (scl_sync),
  .sda_oe    (sda_oe),
  .stop_evt  (stop_evt),
  .clk_in    (clk_in),
  .gate_en   (gate_en),
  .cfg_flat  (cfg_flat)
);

// File: tb/clkgate_smbus_ctrl_tb.sv
module clkgate_smbus_ctrl_tb;
  logic        sys_clk = 1'b0, sys_rst_n = 1'b0, scl = 1'b1, sda_drv = 1'b1;
  logic        clk_in = 1'b0, out_en = 1'b1;
  wire         sda_oe;
  wire  [17:0] clk_out, clk_oe;
  wire         sda_line = sda_drv & ~sda_oe;

  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [7:0]  exp_reg [3];
  logic [7:0]  dat [8];

  always #4 sys_clk = ~sys_clk;           // 125 MHz
  initial begin #3; forever #20 clk_in = ~clk_in; end

  clkgate_smbus_ctrl u_dut (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .clk_in(clk_in), .out_en(out_en),
    .clk_out(clk_out), .clk_oe(clk_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected enables, rebuilt bit by bit from the bank model.
  function automatic logic [17:0] expect_en();
    logic [17:0] e;
    for (int i = 0; i < 18; i++)
      e[i] = (i < 16) ? exp_reg[i / 8][i % 8] : exp_reg[2][i - 10];
    return e;
  endfunction

  task automatic tick(input int n); repeat (n) @(negedge sys_clk); endtask

  task automatic bus_start();
    sda_drv = 1'b1; tick(10); scl = 1'b1; tick(10);
    sda_drv = 1'b0; tick(10); scl = 1'b0; tick(10);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; tick(10); scl = 1'b1; tick(10); sda_drv = 1'b1; tick(10);
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; tick(10); scl = 1'b1; tick(20); scl = 1'b0; tick(10);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int k = 7; k >= 0; k--) send_bit(b[k]);
    sda_drv = 1'b1; tick(10); scl = 1'b1; tick(10);
    ack = (sda_line == 1'b0);
    tick(10); scl = 1'b0; tick(10);
  endtask

  task automatic xfer(input int nbytes, input logic [7:0] abyte, input logic want_ack);
    logic a;
    bus_start();
    wr_byte(abyte, a);
    chk(want_ack ? "R2 address ack" : "R2/R3 address no-ack", a, want_ack);
    if (a) begin
      for (int k = 0; k < nbytes; k++) begin
        wr_byte(dat[k], a);
        chk(k < 3 ? "R4 data ack" : "R10 extra byte ack", a, 1'b1);
        if (k < 3) exp_reg[k] = dat[k];
      end
    end
    bus_stop();
    tick(20);
  endtask

  task automatic check_outputs(input string tag);
    logic [17:0] first;
    repeat (2) @(negedge clk_in);
    @(posedge clk_in); #5;
    first = clk_out;
    chk({tag, " R6 high phase"}, 32'(clk_out), 32'(expect_en()));
    #10;
    chk({tag, " R11 steady in high"}, 32'(clk_out), 32'(first));
    @(negedge clk_in); #5;
    chk({tag, " R6 low phase"}, 32'(clk_out), 32'h0);
    chk({tag, " R7 drive"}, 32'(clk_oe), out_en ? 32'h3FFFF : 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge sys_clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic a;
    void'($urandom(32'h5EED_1234));
    exp_reg[0] = 8'hFF; exp_reg[1] = 8'hFF; exp_reg[2] = 8'hC0;
    tick(10); sys_rst_n = 1'b1; tick(10);

    chk("R1 sda released", sda_oe, 1'b0);
    check_outputs("R1 reset");

    out_en = 1'b0; tick(5);
    chk("R7 hi-z", 32'(clk_oe), 32'h0);
    out_en = 1'b1; tick(5);

    dat[0] = 8'h00; dat[1] = 8'h00; dat[2] = 8'h00;
    xfer(3, 8'hD2, 1'b1);
    check_outputs("R6 all off");

    dat[0] = 8'hFF;
    xfer(1, 8'hD0, 1'b0);                 // R2 wrong address
    check_outputs("R2 ignored");
    xfer(1, 8'hD3, 1'b0);                 // R3 read request
    check_outputs("R3 ignored");

    dat[0] = 8'hA5; xfer(1, 8'hD2, 1'b1);
    dat[0] = 8'h3C; xfer(1, 8'hD2, 1'b1); // R9 stop resets pointer
    check_outputs("R9 after stop");

    // R9 repeated start mid-stream
    bus_start(); wr_byte(8'hD2, a);
    wr_byte(8'h11, a); exp_reg[0] = 8'h11;
    wr_byte(8'h22, a); exp_reg[1] = 8'h22;
    bus_start(); wr_byte(8'hD2, a);
    chk("R9 address after restart", a, 1'b1);
    wr_byte(8'h77, a); exp_reg[0] = 8'h77;
    bus_stop(); tick(20);
    check_outputs("R9 restart");

    // R10 five bytes, last two discarded
    dat[0] = 8'h5A; dat[1] = 8'hC3; dat[2] = 8'h40; dat[3] = 8'h00; dat[4] = 8'h00;
    xfer(5, 8'hD2, 1'b1);
    check_outputs("R10 extra bytes");

    // R8 stop inside a byte
    bus_start(); wr_byte(8'hD2, a);
    for (int k = 0; k < 5; k++) send_bit(1'b1);
    bus_stop(); tick(20);
    check_outputs("R8 partial byte");

    // R5 reserved bits inert, feedback copies mapped
    dat[0] = 8'hFF; dat[1] = 8'hFF; dat[2] = 8'h3F;
    xfer(3, 8'hD2, 1'b1);
    check_outputs("R5 reserved");
    dat[2] = 8'h80; xfer(3, 8'hD2, 1'b1);
    check_outputs("R5 bit7");
    dat[2] = 8'h40; xfer(3, 8'hD2, 1'b1);
    check_outputs("R5 bit6");

    for (int it = 0; it < 14; it++) begin
      int n;
      n = 1 + int'($urandom % 5);
      for (int k = 0; k < 8; k++) dat[k] = 8'($urandom);
      xfer(n, 8'hD2, 1'b1);
      check_outputs("R5 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule